// File: doc/BRIEF.md
# Address-Decoded Bus Wait-State Generator

This block decides, for each processor bus cycle, how many wait states the cycle takes. It then drives the processor's READY line to match. A one-cycle start strobe marks the start of a cycle. With it come a 20-bit address and a flag that tells a memory access from an I/O access. The block uses these to place the cycle in one of two classes.

- **Fast class:** memory accesses whose top address bit is 0 (the lower half of the 1 MB space). These always finish with no wait state.
- **Slow class:** memory accesses in the upper half, and all I/O accesses. These take a fixed minimum of wait states (one by default). After that minimum, a slow device can stretch the cycle by holding an active-low hold line. The stretch has no limit.

The processor sees READY low during every wait state. A one-cycle completion flag marks the clock in which the cycle ends. A fast cycle cannot be stretched: the hold line has no effect on it.

The wait count W of a cycle is the number of clock edges from the edge that samples the start strobe to the edge after which the completion flag is high. Every output is registered.

Top module: `bus_wait_ctrl`

## Requirements
- R1: A memory cycle (`cyc_is_mem`=1) with address bit 19 = 0 has W = 0. `cyc_done` and `cpu_ready` are both 1 in the clock after the edge that samples `cyc_start`.
- R2: In such a lower-memory cycle, `ext_hold_n` has no effect. The cycle still has W = 0 when the hold line is held low.
- R3: A memory cycle with address bit 19 = 1 has W >= MIN_WAITS (default 1). `cpu_ready` is 0 in the clock after the start edge.
- R4: An I/O cycle (`cyc_is_mem`=0) has W >= MIN_WAITS whatever its address, including addresses with bit 19 = 0.
- R5: In a slow cycle, `ext_hold_n` is first sampled at the edge that ends the last mandatory wait, and then at each edge after it. If it is sampled low at N consecutive edges and then high, W = MIN_WAITS + N. There is no timeout.
- R6: `cpu_ready` is 0 in exactly the W wait clocks of a cycle and 1 at all other times. `cyc_done` is high for one clock, the completion clock, and `cpu_ready` is 1 in that clock.
- R7: A `cyc_start` pulse that arrives while a slow cycle is in its wait states is ignored. It neither ends nor restarts the cycle.
- R8: After synchronous reset, `cpu_ready` = 1 and `cyc_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe marking a new bus cycle |
| cyc_addr | input | 20 | Address of the cycle, sampled with the strobe |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| ext_hold_n | input | 1 | Active-low wait extension request from slow devices |
| cpu_ready | output | 1 | READY to the processor, low during wait states |
| cyc_done | output | 1 | One-clock pulse in the completion clock |

## Verification
The hardest situations to reach are a long stretch that must not time out, and a new start strobe that arrives in the middle of a stretched cycle. The bench drives the hold line clock by clock from a schedule computed for each cycle, so that exactly N low samples land on the sampling edges. It then counts the edges until the completion flag appears. For the mid-cycle case, it raises the strobe again with a fast-class address while a slow cycle is still waiting. It then checks that the cycle ends neither early nor late.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAND = 2'd1,
    ST_EXT  = 2'd2
  } seq_state_t;

  typedef enum logic {
    CLS_FAST = 1'b0,
    CLS_SLOW = 1'b1
  } cyc_class_t;
endpackage

// File: rtl/bus_region_decode.sv
module bus_region_decode #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     is_mem,
  output bus_wait_pkg::cyc_class_t cls
);
  import bus_wait_pkg::*;

  localparam int SPLIT_BIT = ADDR_W - 1;

  logic upper_half;

  assign upper_half = addr[SPLIT_BIT];

  always_comb begin
    if (is_mem && !upper_half) cls = CLS_FAST;
    else                       cls = CLS_SLOW;
  end
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq #(
  parameter int MIN_WAITS = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  bus_wait_pkg::cyc_class_t cls,
  input  logic                     hold_n,
  output logic                     ready,
  output logic                     done,
  output logic                     busy
);
  import bus_wait_pkg::*;

  localparam int CNT_W = (MIN_WAITS > 1) ? $clog2(MIN_WAITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_WAITS - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] mand_cnt;
  logic             mand_last;

  assign mand_last = (mand_cnt == '0);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mand_cnt <= '0;
      ready    <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          ready <= 1'b1;
          if (start) begin
            if (cls == CLS_FAST) begin
              done <= 1'b1;
            end else begin
              state    <= ST_MAND;
              mand_cnt <= CNT_LOAD;
              ready    <= 1'b0;
            end
          end
        end
        ST_MAND: begin
          if (!mand_last) begin
            mand_cnt <= mand_cnt - 1'b1;
          end else if (hold_n) begin
            state <= ST_IDLE;
            ready <= 1'b1;
            done  <= 1'b1;
          end else begin
            state <= ST_EXT;
          end
        end
        ST_EXT: begin
          if (hold_n) begin
            state <= ST_IDLE;
            ready <= 1'b1;
            done  <= 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          ready <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int ADDR_W    = 20,
  parameter int MIN_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_is_mem,
  input  logic              ext_hold_n,
  output logic              cpu_ready,
  output logic              cyc_done
);
  import bus_wait_pkg::*;

  cyc_class_t cls;
  logic       seq_busy;

  bus_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (cyc_addr),
    .is_mem (cyc_is_mem),
    .cls    (cls)
  );

  bus_wait_seq #(.MIN_WAITS(MIN_WAITS)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (cyc_start),
    .cls    (cls),
    .hold_n (ext_hold_n),
    .ready  (cpu_ready),
    .done   (cyc_done),
    .busy   (seq_busy)
  );
endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_start,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic              cyc_is_mem,
  input logic              ext_hold_n,
  input logic              cpu_ready,
  input logic              cyc_done,
  input logic              seq_busy
);
  logic fast_req;
  assign fast_req = cyc_is_mem && !cyc_addr[ADDR_W-1];

  // R1, R2: a fast cycle finishes in the next clock
  p_fast_zero_wait_r1: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !seq_busy && fast_req) |=> (cyc_done && cpu_ready));

  // R3, R4: a slow cycle opens with a wait state
  p_slow_min_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !seq_busy && !fast_req) |=> (!cpu_ready && !cyc_done));

  // R5: a hold sampled low during a wait keeps the cycle open
  p_hold_extends_r5: assert property (@(posedge clk) disable iff (rst)
    (!cpu_ready && !ext_hold_n) |=> !cyc_done);

  // R6: completion is always seen with READY high
  p_done_with_ready_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_done |-> cpu_ready);

  // R7: a strobe during waits does not complete the cycle
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !cpu_ready && !ext_hold_n) |=> !cyc_done);
endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cyc_start  (cyc_start),
  .cyc_addr   (cyc_addr),
  .cyc_is_mem (cyc_is_mem),
  .ext_hold_n (ext_hold_n),
  .cpu_ready  (cpu_ready),
  .cyc_done   (cyc_done),
  .seq_busy   (seq_busy)
);

// File: tb/sim_bus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_bus_wait_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_start = 1'b0;
  logic [19:0] cyc_addr = '0;
  logic        cyc_is_mem = 1'b1;
  logic        ext_hold_n = 1'b1;
  logic        cpu_ready;
  logic        cyc_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bus_wait_ctrl u0 (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
    .cyc_is_mem(cyc_is_mem), .ext_hold_n(ext_hold_n),
    .cpu_ready(cpu_ready), .cyc_done(cyc_done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one bus cycle and measures W. hold_cnt = number of low samples of
  // the hold line at the sampling edges (MIN_WAITS = 1, so sampling starts at
  // the first edge after the start edge). For fast cycles the line is held
  // low anyway. glitch raises a fast-class strobe one clock into the cycle.
  task automatic run_cycle(string req, logic [19:0] a, logic m,
                           int hold_cnt, int exp_w, bit glitch);
    int got;
    int bad_ready;
    got = -1;
    bad_ready = 0;
    @(negedge clk);
    cyc_addr   = a;
    cyc_is_mem = m;
    cyc_start  = 1'b1;
    ext_hold_n = (hold_cnt > 0) ? 1'b0 : 1'b1;
    for (int k = 0; k < hold_cnt + 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (glitch && k == 0) begin
        cyc_start  = 1'b1;
        cyc_addr   = 20'h00010;
        cyc_is_mem = 1'b1;
      end else begin
        cyc_start = 1'b0;
      end
      if (cyc_done) begin
        got = k;
        check({req, " ready in completion clock"}, int'(cpu_ready), 1);
        break;
      end
      if (cpu_ready) bad_ready++;
      ext_hold_n = (k + 1 <= hold_cnt) ? 1'b0 : 1'b1;
    end
    cyc_start = 1'b0;
    check({req, " wait count"}, got, exp_w);
    check({req, " R6 ready low in waits"}, bad_ready, 0);
    ext_hold_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({req, " R6 idle done low"}, int'(cyc_done), 0);
    check({req, " R6 idle ready high"}, int'(cpu_ready), 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset ready", int'(cpu_ready), 1);
    check("R8 reset done", int'(cyc_done), 0);
    rst = 1'b0;
  endtask

  task automatic t_low_mem();
    run_cycle("R1 low mem", 20'h12345, 1'b1, 0, 0, 1'b0);
    run_cycle("R2 low mem hold low ignored", 20'h7FFFF, 1'b1, 4, 0, 1'b0);
  endtask

  task automatic t_upper_mem();
    run_cycle("R3 upper mem min", 20'h80000, 1'b1, 0, 1, 1'b0);
    run_cycle("R5 upper mem hold 3", 20'hFFFFF, 1'b1, 3, 4, 1'b0);
  endtask

  task automatic t_io();
    run_cycle("R4 io low addr", 20'h00040, 1'b0, 0, 1, 1'b0);
    run_cycle("R4 io high addr hold 5", 20'hC0000, 1'b0, 5, 6, 1'b0);
  endtask

  task automatic t_long_hold();
    run_cycle("R5 long hold no timeout", 20'h90000, 1'b1, 300, 301, 1'b0);
  endtask

  task automatic t_start_ignored();
    run_cycle("R7 strobe during waits", 20'hA0000, 1'b1, 2, 3, 1'b1);
  endtask

  initial begin
    t_reset();
    t_low_mem();
    t_upper_mem();
    t_io();
    t_long_hold();
    t_start_ignored();
    run_cycle("R1 back to back fast", 20'h00000, 1'b1, 0, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule